// File: doc/BRIEF.md
# Masked Sticky Interrupt Collector

This block gathers fourteen event lines from a stream-processing datapath and turns them into a single active-low interrupt request for a host controller. Each line is first gated by its own enable bit. Any line that passes the gate is recorded in a sticky pending register, and the request line stays driven low for as long as that register holds a nonzero value.

The host reaches the block through a plain register port made of a select strobe, a write flag, an address, write data and read data. It can see three things. The first is the live level of every source, which is read-only, so the host can poll a condition such as a buffer draining without waiting for an event. The second is the enable register, which is write-only. The third is the pending register. Any access to the pending register's address returns its contents and clears it in the same cycle. A host that only wants to look at the enables or the live levels must therefore keep away from that address, or it will lose events.

The request line is produced by a two-state machine. `REQ_IDLE` means nothing is pending. `REQ_RAISED` means at least one bit is pending. The transition *idle→raised* ("fire") is taken on any cycle where an enabled source is active. The transition *raised→idle* ("drain") is taken on a cycle where the pending address is accessed and no enabled source is active. In every other case the machine stays in its current state.

Top module: `irq_latch_ctrl`

## Requirements
- R1: After reset the enable register and the pending register are all zeros, and `irq_n` is high.
- R2: A write (`sel`=1, `wr`=1) to address 0x0001 loads `wdata[13:0]` into the enable register at the clock edge, and the upper write-data bits are ignored. A read of 0x0001 returns zero.
- R3: A read (`sel`=1, `wr`=0) of address 0x0002 returns the live `src` levels in bits 13:0, with zeros above, in the same cycle. A write to 0x0002 has no effect.
- R4: Pending bit i becomes 1 at the clock edge that ends any cycle in which `src[i]` and enable bit i are both 1. The enable value used is the one held before that edge.
- R5: A source whose enable bit is 0 never sets its pending bit and never pulls `irq_n` low.
- R6: A pending bit stays at 1 after its source returns to 0, until the pending address is accessed.
- R7: `irq_n` is low exactly when the pending register is nonzero, and it changes at the same clock edge as that register.
- R8: Any access (read or write) with `sel`=1 and address 0x0000 clears the whole pending register at that clock edge. A read in that cycle returns the value from before the clear, zero-extended to 16 bits.
- R9: When an enabled source is active in the same cycle as the clear, its bit is 1 after the edge.
- R10: When `sel` is 0, or the address is not 0x0000, 0x0001 or 0x0002, `rdata` is zero and the enable and pending registers are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src | input | 14 | Live event levels from the datapath |
| sel | input | 1 | Host access strobe for the current cycle |
| wr | input | 1 | 1 selects a write access, 0 a read access |
| addr | input | 16 | Register address for the access |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid in the cycle of a read access |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
A corrupted pending bit shows up on `irq_n` one edge after the faulty update. It also shows up in the next read of 0x0000, because that read reports the stored value without any further delay. A wrong enable bit shows up at the first edge on which its source is active, either as a missing or unexpected pending bit or as a wrong `irq_n` level. A drift between the request state machine and the pending register shows up as an `irq_n` level that does not match the register contents on the very next read. A clear that is missed or applied twice shows up on the read that follows the clearing access.

// File: rtl/irq_pkg.sv
package irq_pkg;

    // Request line state: nothing pending, or at least one pending bit.
    typedef enum logic [0:0] {
        REQ_IDLE   = 1'b0,
        REQ_RAISED = 1'b1
    } req_state_e;

    // Default register map of the host port.
    localparam logic [15:0] DEF_PEND_ADDR = 16'h0000;
    localparam logic [15:0] DEF_MASK_ADDR = 16'h0001;
    localparam logic [15:0] DEF_LIVE_ADDR = 16'h0002;

endpackage

// File: rtl/irq_addr_decode.sv
module irq_addr_decode #(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] PEND_ADDR = 16'h0000,
    parameter logic [15:0] MASK_ADDR = 16'h0001,
    parameter logic [15:0] LIVE_ADDR = 16'h0002
) (
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output logic              pend_touch,
    output logic              pend_rd,
    output logic              mask_we,
    output logic              live_rd
);

    localparam logic [ADDR_W-1:0] PEND_A = ADDR_W'(PEND_ADDR);
    localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(MASK_ADDR);
    localparam logic [ADDR_W-1:0] LIVE_A = ADDR_W'(LIVE_ADDR);

    logic hit_pend;
    logic hit_mask;
    logic hit_live;

    always_comb begin
        hit_pend = (addr == PEND_A);
        hit_mask = (addr == MASK_A);
        hit_live = (addr == LIVE_A);
    end

    always_comb begin
        // Any access to the pending location counts as a clear, reads and writes alike.
        pend_touch = sel && hit_pend;
        pend_rd    = sel && !wr && hit_pend;
        mask_we    = sel &&  wr && hit_mask;
        live_rd    = sel && !wr && hit_live;
    end

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
    parameter int NUM_SRC = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [NUM_SRC-1:0] d,
    output logic [NUM_SRC-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (we) begin
            q <= d;
        end
    end

endmodule

// File: rtl/irq_latch_bank.sv
module irq_latch_bank #(
    parameter int NUM_SRC = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic [NUM_SRC-1:0] src,
    input  logic [NUM_SRC-1:0] enable,
    output logic [NUM_SRC-1:0] pend,
    output logic               set_any
);

    logic [NUM_SRC-1:0] gated;

    always_comb begin
        gated   = src & enable;
        set_any = |gated;
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pend[i] <= 1'b0;
            end else if (gated[i]) begin
                // A set wins over a clear in the same cycle.
                pend[i] <= 1'b1;
            end else if (clr) begin
                pend[i] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/irq_req_fsm.sv
module irq_req_fsm
    import irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic set_any,
    output logic irq_n
);

    req_state_e state_q;
    req_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= REQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            REQ_IDLE: begin
                // fire
                if (set_any) begin
                    state_d = REQ_RAISED;
                end
            end
            REQ_RAISED: begin
                // drain
                if (clr && !set_any) begin
                    state_d = REQ_IDLE;
                end
            end
            default: state_d = REQ_IDLE;
        endcase
    end

    always_comb begin
        irq_n = (state_q != REQ_RAISED);
    end

endmodule

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl
    import irq_pkg::*;
#(
    parameter int          NUM_SRC   = 14,
    parameter int          DATA_W    = 16,
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] PEND_ADDR = DEF_PEND_ADDR,
    parameter logic [15:0] MASK_ADDR = DEF_MASK_ADDR,
    parameter logic [15:0] LIVE_ADDR = DEF_LIVE_ADDR
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src,
    input  logic               sel,
    input  logic               wr,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    output logic               irq_n
);

    logic               pend_touch;
    logic               pend_rd;
    logic               mask_we;
    logic               live_rd;
    logic               set_any;
    logic [NUM_SRC-1:0] mask_vec;
    logic [NUM_SRC-1:0] latch_vec;

    irq_addr_decode #(
        .ADDR_W    (ADDR_W),
        .PEND_ADDR (PEND_ADDR),
        .MASK_ADDR (MASK_ADDR),
        .LIVE_ADDR (LIVE_ADDR)
    ) u_decode (
        .sel        (sel),
        .wr         (wr),
        .addr       (addr),
        .pend_touch (pend_touch),
        .pend_rd    (pend_rd),
        .mask_we    (mask_we),
        .live_rd    (live_rd)
    );

    irq_mask_reg #(
        .NUM_SRC (NUM_SRC)
    ) u_mask (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mask_we),
        .d     (wdata[NUM_SRC-1:0]),
        .q     (mask_vec)
    );

    irq_latch_bank #(
        .NUM_SRC (NUM_SRC)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (pend_touch),
        .src     (src),
        .enable  (mask_vec),
        .pend    (latch_vec),
        .set_any (set_any)
    );

    irq_req_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (pend_touch),
        .set_any (set_any),
        .irq_n   (irq_n)
    );

    // Read mux: the pending read sees the register before the clearing edge.
    always_comb begin
        rdata = '0;
        if (pend_rd) begin
            rdata = DATA_W'(latch_vec);
        end else if (live_rd) begin
            rdata = DATA_W'(src);
        end
    end

endmodule

// File: rtl/irq_latch_chk.sv
module irq_latch_chk #(
    parameter int          NUM_SRC   = 14,
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] PEND_ADDR = 16'h0000
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sel,
    input logic [ADDR_W-1:0]  addr,
    input logic [NUM_SRC-1:0] src,
    input logic               irq_n,
    input logic [NUM_SRC-1:0] mask_q,
    input logic [NUM_SRC-1:0] latch_q
);

    logic               touch;
    logic [NUM_SRC-1:0] live_en;

    always_comb begin
        touch   = sel && (addr == ADDR_W'(PEND_ADDR));
        live_en = src & mask_q;
    end

    // R7
    irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_n == (latch_q == '0));

    // R4
    enabled_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_en != '0) |=> !irq_n);

    // R5
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((latch_q & ~$past(latch_q) & ~$past(live_en)) == '0));

    // R6
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !touch |=> ((latch_q & $past(latch_q)) == $past(latch_q)));

    // R8
    clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (touch && live_en == '0) |=> (latch_q == '0));

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        touch |=> (latch_q == $past(live_en)));

endmodule

bind irq_latch_ctrl irq_latch_chk #(
    .NUM_SRC   (NUM_SRC),
    .ADDR_W    (ADDR_W),
    .PEND_ADDR (PEND_ADDR)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (sel),
    .addr    (addr),
    .src     (src),
    .irq_n   (irq_n),
    .mask_q  (mask_vec),
    .latch_q (latch_vec)
);

// File: tb/irq_latch_ctrl_bench.sv
module irq_latch_ctrl_bench;

    localparam int NS = 14;
    localparam int DW = 16;
    localparam int AW = 16;

    logic          clk   = 1'b0;
    logic          rst_n = 1'b1;
    logic [NS-1:0] src   = '0;
    logic          sel   = 1'b0;
    logic          wr    = 1'b0;
    logic [AW-1:0] addr  = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          irq_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [NS-1:0] m_pend = '0;
    logic [NS-1:0] m_mask = '0;

    always #2 clk = ~clk;

    irq_latch_ctrl u_irq_latch_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .src   (src),
        .sel   (sel),
        .wr    (wr),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .irq_n (irq_n)
    );

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One bus cycle: drive, check against the model, advance the model.
    task automatic step(input logic [NS-1:0] s, input logic sl, input logic w,
                        input logic [AW-1:0] a, input logic [DW-1:0] d, input string tg);
        logic [DW-1:0] exp_rd;
        string         t;
        @(negedge clk);
        src = s; sel = sl; wr = w; addr = a; wdata = d;
        #1;
        exp_rd = '0;
        if (sl && !w) begin
            if (a == 16'h0000)      exp_rd = DW'(m_pend);
            else if (a == 16'h0002) exp_rd = DW'(s);
        end
        t = tg;
        if (t == "") begin
            if (!sl)                 t = "R10";
            else if (a == 16'h0000)  t = "R8";
            else if (a == 16'h0001)  t = "R2";
            else if (a == 16'h0002)  t = "R3";
            else                     t = "R10";
        end
        chk(t, rdata, exp_rd);
        chk("R7", DW'(irq_n), DW'(m_pend == '0));
        m_pend = ((sl && a == 16'h0000) ? '0 : m_pend) | (s & m_mask);
        if (sl && w && a == 16'h0001) m_mask = d[NS-1:0];
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #1 rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", DW'(irq_n), 16'h0001);
        rst_n = 1'b1;

        // R1: reset contents seen through the port
        step('0, 1'b1, 1'b0, 16'h0000, '0, "R1");
        step('1, 1'b0, 1'b0, 16'h0000, '0, "R1");
        step('0, 1'b1, 1'b0, 16'h0000, '0, "R1");

        // R3: live level sweep with everything disabled (R5)
        for (int i = 0; i < NS; i++) step(NS'(1) << i, 1'b1, 1'b0, 16'h0002, '0, "");
        step('1, 1'b1, 1'b0, 16'h0002, '0, "R3");
        step('0, 1'b1, 1'b0, 16'h0000, '0, "R5");

        // R3: write to the live location is ignored; R2: enable reads as zero
        step('0, 1'b1, 1'b1, 16'h0002, 16'hffff, "R3");
        step('0, 1'b1, 1'b0, 16'h0001, '0, "R2");
        step('1, 1'b0, 1'b0, 16'h0000, '0, "R5");
        step('0, 1'b1, 1'b0, 16'h0000, '0, "R5");

        // R4, R5, R6, R8: single enable bit against all sources
        for (int i = 0; i < NS; i++) begin
            step('0, 1'b1, 1'b1, 16'h0001, DW'(1) << i, "R2");
            step('1, 1'b0, 1'b0, 16'h0000, '0, "R4");
            step('0, 1'b0, 1'b0, 16'h0000, '0, "R6");
            step('0, 1'b0, 1'b0, 16'h0000, '0, "R6");
            step('0, 1'b1, 1'b0, 16'h0000, '0, "R6");
            step('0, 1'b1, 1'b0, 16'h0000, '0, "R8");
        end

        // R4: exhaustive enable x source over the low four bits
        for (int m = 0; m < 16; m++) begin
            for (int s = 0; s < 16; s++) begin
                step('0, 1'b1, 1'b1, 16'h0001, DW'(m), "R2");
                step(NS'(s), 1'b0, 1'b0, 16'h0000, '0, "R4");
                step('0, 1'b1, 1'b0, 16'h0000, '0, "R4");
            end
        end

        // R9: set during clear survives
        step('0, 1'b1, 1'b1, 16'h0001, 16'h3fff, "R2");
        step(14'h0005, 1'b0, 1'b0, 16'h0000, '0, "R9");
        step(14'h0300, 1'b1, 1'b0, 16'h0000, '0, "R9");
        step('0, 1'b1, 1'b0, 16'h0000, '0, "R9");
        step('0, 1'b1, 1'b0, 16'h0000, '0, "R8");

        // R8: a write access also clears
        step(14'h00ff, 1'b0, 1'b0, 16'h0000, '0, "R4");
        step('0, 1'b1, 1'b1, 16'h0000, 16'h1234, "R8");
        step('0, 1'b1, 1'b0, 16'h0000, '0, "R8");

        // R2: upper write bits ignored
        step('0, 1'b1, 1'b1, 16'h0001, 16'hc001, "R2");
        step('1, 1'b0, 1'b0, 16'h0000, '0, "R2");
        step('0, 1'b1, 1'b0, 16'h0000, '0, "R2");

        // R10: unmapped and unselected accesses
        step('0, 1'b1, 1'b1, 16'h0001, 16'h2a55, "R2");
        step('1, 1'b0, 1'b0, 16'h0000, '0, "R4");
        step('0, 1'b1, 1'b0, 16'h0123, '0, "R10");
        step('0, 1'b1, 1'b1, 16'h1001, 16'h0000, "R10");
        step('0, 1'b1, 1'b0, 16'h1000, '0, "R10");
        step('0, 1'b0, 1'b1, 16'h0000, '0, "R10");
        step('0, 1'b1, 1'b0, 16'h0000, '0, "R10");
        step(14'h3fff, 1'b0, 1'b0, 16'h0000, '0, "R10");
        step('0, 1'b1, 1'b0, 16'h0000, '0, "R10");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule